// File: doc/BRIEF.md
# Asynchronous FIFO write strobe sequencer

This block is the master side of a write link to an external slave FIFO that is driven by strobes with no clock. A user issues requests on a valid/ready port. Each request is either a data byte for one FIFO address or a commit that closes the current packet. The block turns each request into chip select, address, data, write-strobe and packet-end waveforms. It shapes them in clock cycles so that every setup time, hold time and pulse width the FIFO asks for is met. Each setting is a parameter given in cycles.

The first request opens a bus window. Chip select goes low together with the address, and the first strobe waits for the address setup time. Later requests to the same address, with valid held high, are sent as a burst inside the same window. Each byte is committed by the FIFO on the rising edge of the write strobe. A commit becomes a packet-end pulse, which comes only after the write strobe has been high for its full minimum time. The window closes when valid drops or the address changes. The address is then held for its hold time before chip select is released.

The FIFO full flag is registered. It stalls the user port while it is active. After each strobe rising edge, the flag is not trusted until a set latency has passed.

Top module: `fifo_wr_seq`

## Requirements
- R1: When a bus window opens, address and active-low chip select are driven for at least ADDR_SETUP cycles before the first strobe goes low. The address does not change while any strobe is low.
- R2: Chip select is low whenever the write strobe or the packet-end strobe is low. After reset, chip select, write strobe and packet-end are all high (inactive).
- R3: The write strobe is low for exactly max(WR_LOW, DATA_SETUP) cycles. Between two strobes it stays high for at least max(WR_HIGH, DATA_HOLD) cycles.
- R4: A request with commit bit 0 writes one byte. The FIFO sees the accepted byte, in acceptance order, on the data bus for the whole low phase of its write strobe. The byte stays unchanged for at least DATA_HOLD cycles after the strobe rises.
- R5: Chip select rises only after at least ADDR_HOLD cycles have passed since the last strobe rose, and never while a strobe is low.
- R6: A request to the same address that is accepted while valid stays high after a strobe is added to the open window as a burst. Chip select is not released between the bytes.
- R7: The packet-end strobe is never low in the same cycle as the write strobe. It falls only after the write strobe has been high for at least WR_HIGH cycles.
- R8: A request with commit bit 1 ignores its data and makes one packet-end pulse, low for exactly PE_LOW cycles. The next strobe of either kind follows only after at least PE_HIGH cycles of packet-end high time.
- R9: The address stays constant for the whole packet-end low pulse.
- R10: While the full flag was high at the previous clock edge, ready is low and no request is accepted.
- R11: For FLAG_LAT cycles after any strobe rises, ready stays low.
- R12: If valid drops or the address changes while a window is open, the window closes (address hold, then chip select high). A request for a new address opens a new window with a new address setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | User request valid |
| req_ready_o | output | 1 | User request accepted this cycle when high with valid |
| req_commit_i | input | 1 | 1 = packet-end request, 0 = byte write |
| req_addr_i | input | AW | Target FIFO address |
| req_data_i | input | DW | Byte to write (ignored for commit) |
| fifo_full_i | input | 1 | FIFO full flag, active high |
| fifo_addr_o | output | AW | FIFO address bus |
| fifo_cs_n_o | output | 1 | Chip select, active low |
| fifo_wr_n_o | output | 1 | Write strobe, active low, byte taken on rising edge |
| fifo_data_o | output | DW | Write data bus |
| fifo_pktend_n_o | output | 1 | Packet-end strobe, active low |

## Verification
The hardest case to reach is a packet-end that follows a write burst directly inside one window. For it, valid must stay high across several strobes while ready is held low by the flag latency window, so the user's request is stalled and not lost. The stimulus keeps valid asserted through a three-byte burst followed by a commit to the same address. A monitor measures every low and high run, the setup and hold counts, and the address across the packet-end pulse. Separate sequences cover an address change with valid held, a full flag raised while a request waits, and two commits back to back.

// File: rtl/fifo_wr_pkg.sv
package fifo_wr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_WR_LO,
    S_WR_HI,
    S_PE_LO,
    S_PE_HI,
    S_OPEN,
    S_HOLD
  } wr_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fifo_wr_timer.sv
module fifo_wr_timer #(
  parameter int unsigned TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/fifo_wr_flag_qual.sv
module fifo_wr_flag_qual #(
  parameter int unsigned FLAG_LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_rise_i,
  output logic flag_ok_o
);
  localparam int unsigned FW = $clog2(FLAG_LAT + 2);

  logic [FW-1:0] cnt_q;

  // flag from the FIFO is stale until FLAG_LAT cycles after a strobe edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (strobe_rise_i) cnt_q <= FW'(FLAG_LAT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign flag_ok_o = (cnt_q == '0);
endmodule

// File: rtl/fifo_wr_hold.sv
module fifo_wr_hold #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          commit_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          commit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      data_o   <= '0;
      commit_o <= 1'b0;
    end else if (load_i) begin
      addr_o   <= addr_i;
      commit_o <= commit_i;
      // commit requests leave the data bus alone
      if (!commit_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/fifo_wr_seq.sv
module fifo_wr_seq
  import fifo_wr_pkg::*;
#(
  parameter int unsigned AW         = 2,
  parameter int unsigned DW         = 8,
  parameter int unsigned ADDR_SETUP = 2,
  parameter int unsigned ADDR_HOLD  = 2,
  parameter int unsigned WR_LOW     = 3,
  parameter int unsigned WR_HIGH    = 2,
  parameter int unsigned DATA_SETUP = 2,
  parameter int unsigned DATA_HOLD  = 3,
  parameter int unsigned PE_LOW     = 2,
  parameter int unsigned PE_HIGH    = 3,
  parameter int unsigned FLAG_LAT   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_commit_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          fifo_full_i,
  output logic [AW-1:0] fifo_addr_o,
  output logic          fifo_cs_n_o,
  output logic          fifo_wr_n_o,
  output logic [DW-1:0] fifo_data_o,
  output logic          fifo_pktend_n_o
);
  localparam int unsigned LO_CYC  = umax(WR_LOW, DATA_SETUP);
  localparam int unsigned HI_CYC  = umax(WR_HIGH, DATA_HOLD);
  localparam int unsigned MAX_DUR = umax(umax(umax(LO_CYC, HI_CYC), umax(PE_LOW, PE_HIGH)),
                                         umax(ADDR_SETUP, ADDR_HOLD));
  localparam int unsigned TW      = $clog2(MAX_DUR + 1);

  wr_state_e     state_q, state_d;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          full_q, flag_ok, accept, addr_match, strobe_rise;
  logic [AW-1:0] addr_q;
  logic          commit_q;

  fifo_wr_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  fifo_wr_flag_qual #(.FLAG_LAT(FLAG_LAT)) u_flag (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strobe_rise_i (strobe_rise),
    .flag_ok_o     (flag_ok)
  );

  fifo_wr_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .addr_i   (req_addr_i),
    .data_i   (req_data_i),
    .commit_i (req_commit_i),
    .addr_o   (addr_q),
    .data_o   (fifo_data_o),
    .commit_o (commit_q)
  );

  // reset to full so nothing is accepted before the flag is first sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b1;
    else         full_q <= fifo_full_i;
  end

  assign addr_match  = (req_addr_i == addr_q);
  assign req_ready_o = flag_ok && !full_q &&
                       ((state_q == S_IDLE) || ((state_q == S_OPEN) && addr_match));
  assign accept      = req_valid_i && req_ready_o;
  assign strobe_rise = tmr_done && ((state_q == S_WR_LO) || (state_q == S_PE_LO));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        state_d  = S_SETUP;
        tmr_load = 1'b1;
        tmr_val  = TW'(ADDR_SETUP - 1);
      end
      S_SETUP: if (tmr_done) begin
        tmr_load = 1'b1;
        if (commit_q) begin
          state_d = S_PE_LO;
          tmr_val = TW'(PE_LOW - 1);
        end else begin
          state_d = S_WR_LO;
          tmr_val = TW'(LO_CYC - 1);
        end
      end
      S_WR_LO: if (tmr_done) begin
        state_d  = S_WR_HI;
        tmr_load = 1'b1;
        tmr_val  = TW'(HI_CYC - 1);
      end
      S_WR_HI: if (tmr_done) state_d = S_OPEN;
      S_PE_LO: if (tmr_done) begin
        state_d  = S_PE_HI;
        tmr_load = 1'b1;
        tmr_val  = TW'(PE_HIGH - 1);
      end
      S_PE_HI: if (tmr_done) state_d = S_OPEN;
      S_OPEN: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (req_commit_i) begin
            state_d = S_PE_LO;
            tmr_val = TW'(PE_LOW - 1);
          end else begin
            state_d = S_WR_LO;
            tmr_val = TW'(LO_CYC - 1);
          end
        end else if (!(req_valid_i && addr_match)) begin
          // bubble or new address: close the window
          state_d  = S_HOLD;
          tmr_load = 1'b1;
          tmr_val  = TW'(ADDR_HOLD - 1);
        end
      end
      S_HOLD: if (tmr_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign fifo_addr_o     = addr_q;
  assign fifo_cs_n_o     = (state_q == S_IDLE);
  assign fifo_wr_n_o     = (state_q != S_WR_LO);
  assign fifo_pktend_n_o = (state_q != S_PE_LO);
endmodule

// File: rtl/fifo_wr_seq_chk.sv
module fifo_wr_seq_chk #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready,
  input logic          full,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] data,
  input logic          cs_n,
  input logic          wr_n,
  input logic          pe_n
);
  // R7
  pe_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_n && !pe_n));

  // R2
  cs_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n || !pe_n) |-> !cs_n);

  // R1
  addr_wr_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n && $past(!wr_n)) |-> $stable(addr));

  // R4
  data_wr_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n && $past(!wr_n)) |-> $stable(data));

  // R9
  addr_pe_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pe_n && $past(!pe_n)) |-> $stable(addr));

  // R10
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(full) |-> !ready);

  // R5
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n) |-> (wr_n && pe_n && $past(wr_n) && $past(pe_n)));
endmodule

bind fifo_wr_seq fifo_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ready  (req_ready_o),
  .full   (fifo_full_i),
  .addr   (fifo_addr_o),
  .data   (fifo_data_o),
  .cs_n   (fifo_cs_n_o),
  .wr_n   (fifo_wr_n_o),
  .pe_n   (fifo_pktend_n_o)
);

// File: tb/fifo_wr_seq_test.sv
module fifo_wr_seq_test;
  localparam int AW = 2, DW = 8;
  localparam int ADDR_SETUP = 2, ADDR_HOLD = 2, WR_LOW = 3, WR_HIGH = 2;
  localparam int DATA_SETUP = 2, DATA_HOLD = 3, PE_LOW = 2, PE_HIGH = 3, FLAG_LAT = 4;
  localparam int LO_CYC = (WR_LOW > DATA_SETUP) ? WR_LOW : DATA_SETUP;
  localparam int HI_CYC = (WR_HIGH > DATA_HOLD) ? WR_HIGH : DATA_HOLD;

  logic clk = 0, rst_n = 0;
  logic valid = 0, commit = 0, full = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic ready, cs_n, wr_n, pe_n;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data;

  always #4 clk = ~clk;

  fifo_wr_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_commit_i(commit), .req_addr_i(addr), .req_data_i(data), .fifo_full_i(full),
    .fifo_addr_o(f_addr), .fifo_cs_n_o(cs_n), .fifo_wr_n_o(wr_n),
    .fifo_data_o(f_data), .fifo_pktend_n_o(pe_n)
  );

  typedef struct { bit c; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t sb[$];

  int checks = 0, fails = 0, cs_rises = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, bit c);
    @(negedge clk);
    valid = 1; addr = a; data = d; commit = c;
    while (!ready) @(negedge clk);
    sb.push_back('{c: c, a: a, d: d});
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit p_wr = 1, p_pe = 1, p_cs = 1, first_win = 1;
  logic [AW-1:0] p_a = '0, pe_a = '0;
  logic [DW-1:0] p_d = '0;
  int since_wr = 1000, since_pe = 1000, since_any = 1000;
  int lo_run = 0, pe_run = 0, stab = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_wr = 1; p_pe = 1; p_cs = 1; first_win = 1; p_d = f_data; p_a = f_addr;
    end else begin
      item_t it;
      if (!wr_n && !pe_n) chk(0, "R7", "both strobes low", 0, 1);
      if (p_wr && !wr_n) begin
        chk(!cs_n, "R2", "cs at write fall", cs_n, 0);
        chk(since_pe >= PE_HIGH, "R8", "pe high before write", since_pe, PE_HIGH);
        if (first_win) chk(stab >= ADDR_SETUP, "R1", "addr setup", stab, ADDR_SETUP);
        else chk(since_wr >= HI_CYC, "R3", "write high between strobes", since_wr, HI_CYC);
        first_win = 0;
      end
      if (!p_wr && wr_n) begin
        chk(lo_run == LO_CYC, "R3", "write low width", lo_run, LO_CYC);
        if (sb.size() == 0) chk(0, "R4", "unexpected write", 0, 1);
        else begin
          it = sb.pop_front();
          chk(it.c == 0, "R4", "write for commit item", 0, 1);
          chk(p_d == it.d, "R4", "byte written", p_d, it.d);
          chk(p_a == it.a, "R4", "write addr", p_a, it.a);
        end
      end
      if (p_pe && !pe_n) begin
        chk(since_wr >= WR_HIGH, "R7", "write high before pe", since_wr, WR_HIGH);
        chk(since_pe >= PE_HIGH, "R8", "pe high between pulses", since_pe, PE_HIGH);
        if (first_win) chk(stab >= ADDR_SETUP, "R1", "addr setup pe", stab, ADDR_SETUP);
        first_win = 0;
        pe_a = f_addr;
      end
      if (!p_pe && pe_n) begin
        chk(pe_run == PE_LOW, "R8", "pe low width", pe_run, PE_LOW);
        chk(p_a == pe_a, "R9", "addr across pe", p_a, pe_a);
        if (sb.size() == 0) chk(0, "R8", "unexpected pe", 0, 1);
        else begin
          it = sb.pop_front();
          chk(it.c == 1, "R8", "pe for byte item", 0, 1);
          chk(p_a == it.a, "R8", "pe addr", p_a, it.a);
        end
      end
      if (f_data != p_d)
        chk(since_wr >= DATA_HOLD, "R4", "data hold", since_wr, DATA_HOLD);
      if (!p_cs && cs_n) begin
        chk(since_any >= ADDR_HOLD, "R5", "addr hold before cs release", since_any, ADDR_HOLD);
        cs_rises++;
        first_win = 1;
      end
      if (since_any < FLAG_LAT || (!p_wr && wr_n) || (!p_pe && pe_n))
        chk(!ready, "R11", "ready in flag latency", ready, 0);
      // counter updates
      if (!wr_n) lo_run = p_wr ? 1 : lo_run + 1;
      if (!pe_n) pe_run = p_pe ? 1 : pe_run + 1;
      if (!p_wr && wr_n) begin since_wr = 0; since_any = 0; end
      if (!p_pe && pe_n) begin since_pe = 0; since_any = 0; end
      since_wr++; since_pe++; since_any++;
      if (cs_n) stab = 0; else if (f_addr != p_a) stab = 1; else stab++;
      p_wr = wr_n; p_pe = pe_n; p_cs = cs_n; p_a = f_addr; p_d = f_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(cs_n == 1, "R2", "cs after reset", cs_n, 1);
    chk(wr_n == 1, "R2", "wr after reset", wr_n, 1);
    chk(pe_n == 1, "R2", "pe after reset", pe_n, 1);
    chk(ready == 1, "R2", "ready after reset", ready, 1);

    // single write
    send(2'd1, 8'hA5, 0);
    idle(20);

    // R6: burst of three bytes then commit, one window
    base = cs_rises;
    send(2'd2, 8'h11, 0);
    send(2'd2, 8'h22, 0);
    send(2'd2, 8'h33, 0);
    send(2'd2, 8'hEE, 1);
    idle(25);
    chk(cs_rises - base == 1, "R6", "windows for burst", cs_rises - base, 1);

    // R8: commit alone, then back-to-back commits
    send(2'd3, 8'h00, 1);
    send(2'd3, 8'h55, 1);
    idle(25);

    // R12: address change with valid held
    base = cs_rises;
    send(2'd0, 8'h5A, 0);
    send(2'd1, 8'hC3, 0);
    idle(25);
    chk(cs_rises - base == 2, "R12", "windows for address change", cs_rises - base, 2);

    // R10: full flag stalls a waiting request
    @(negedge clk); full = 1;
    repeat (2) @(negedge clk);
    valid = 1; addr = 2'd2; data = 8'h7E; commit = 0;
    repeat (6) begin
      @(negedge clk);
      chk(ready == 0, "R10", "ready while full", ready, 0);
      chk(cs_n == 1, "R10", "no window while full", cs_n, 1);
    end
    full = 0;
    while (!ready) @(negedge clk);
    sb.push_back('{c: 0, a: 2'd2, d: 8'h7E});
    @(posedge clk);
    idle(25);

    chk(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule